// File: doc/BRIEF.md
# Sensor Monitor Sequencer with Alarms

This block keeps an eye on a chip's own health without host help. It drives a converter through a fixed channel order. The order covers three internal sensors: a die temperature sensor, a core supply and an auxiliary supply. It then covers a parameterised set of external analog inputs, each of which the host can enable. For every channel the block stores the newest 10-bit result, the largest result seen since reset and the smallest result seen since reset.

The temperature result is compared with an upper alarm threshold and with a shutdown limit. Each supply result is compared with an upper and a lower bound. The temperature alarm and the two supply alarms follow the samples. The power-down request latches once it is set. The host clears it through a control write, and the clear takes effect only once the die has cooled below a release threshold.

The converter connects through a start/done handshake. A host reads and configures the block through a 7-bit address, 32-bit data register port with separate read and write strobes.

Top module: `smon_top`

## Requirements
- R1: Reset state. Every stored latest result reads 0x000, every maximum reads 0x000 and every minimum reads 0x3FF. All alarm outputs and the power-down request are low, and `adc_start` stays low while reset is applied.
- R2: Conversion order. Channels are converted in ascending order and wrap around. Channel 0 is temperature, channel 1 is the core supply, channel 2 is the auxiliary supply, and channels 3 and up are external inputs. Channel i is the i-th entry in that order.
- R3: When a conversion completes, its result is stored as the latest value of that channel. The latest value of channel c is read at address 0x00+c.
- R4: The maximum register (address 0x20+c) keeps the largest result seen on channel c. The minimum register (address 0x40+c) keeps the smallest result seen on channel c.
- R5: The temperature alarm rises on a temperature sample strictly above the alarm threshold (address 0x60). It falls on a later temperature sample at or below that threshold.
- R6: The core supply alarm uses the upper bound at 0x63 and the lower bound at 0x64. The auxiliary supply alarm uses the upper bound at 0x65 and the lower bound at 0x66. Each alarm rises on a sample strictly outside its bounds and falls on a later sample within them, bounds included.
- R7: The power-down request sets on a temperature sample strictly above the limit at 0x61. Once set, it stays high whatever later samples show.
- R8: Writing a 1 to bit 0 of the control register (0x68) clears the power-down request, but only when the latest temperature is below the release threshold (0x62). Otherwise the write is ignored. A write with bit 0 equal to 0 has no effect.
- R9: Writes to the latest, maximum and minimum registers are ignored.
- R10: Read data appears on `rdata` one cycle after the read strobe and holds until the next read. Thresholds read back as written. Unmapped addresses read 0. The status register (0x69) reads bit 0 as the temperature alarm, bit 1 as the core alarm, bit 2 as the auxiliary alarm and bit 3 as the power-down request.
- R11: The external enable mask (0x67) has bit k for channel 3+k and resets to all ones. The sequencer skips disabled channels, and their stored values do not change.
- R12: `adc_start` is a one-cycle pulse. No new start is issued until `adc_done` has returned for the conversion in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_start | output | 1 | One-cycle request to start a conversion |
| adc_chan | output | CW = clog2(3+NUM_EXT) | Channel to convert, held until done |
| adc_done | input | 1 | Conversion complete, with result on `adc_data` |
| adc_data | input | DW (10) | Conversion result |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address |
| wdata | input | BW (32) | Write data |
| rdata | output | BW (32) | Read data, valid one cycle after `rd_en` |
| alarm_temp | output | 1 | Over-temperature alarm |
| alarm_vcore | output | 1 | Core supply out-of-range alarm |
| alarm_vaux | output | 1 | Auxiliary supply out-of-range alarm |
| pd_req | output | 1 | Latched power-down request |

## Verification
The bench targets the strict-versus-inclusive boundaries: a sample equal to a threshold or to the shutdown limit must not raise anything. A design using `>=` would flag an alarm or request a power-down at exactly the limit. It checks that a clear write is refused while the die is still above the release threshold and that a zero write does nothing; a design that cleared unconditionally would drop the shutdown request while the part is still hot. It also checks that writes to result registers leave them unchanged. After the mask changes, it checks that disabled external channels are never converted and keep their old values. A faulty skip would convert a disabled channel or stall the rotation.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int AW      = 7;
  localparam int NUM_INT = 3;
  localparam int CH_TEMP  = 0;
  localparam int CH_VCORE = 1;
  localparam int CH_VAUX  = 2;

  localparam logic [AW-1:0] A_LAST    = 7'h00;
  localparam logic [AW-1:0] A_MAX     = 7'h20;
  localparam logic [AW-1:0] A_MIN     = 7'h40;
  localparam logic [AW-1:0] A_TEMP_HI = 7'h60;
  localparam logic [AW-1:0] A_PD_LIM  = 7'h61;
  localparam logic [AW-1:0] A_PD_REL  = 7'h62;
  localparam logic [AW-1:0] A_VC_HI   = 7'h63;
  localparam logic [AW-1:0] A_VC_LO   = 7'h64;
  localparam logic [AW-1:0] A_VA_HI   = 7'h65;
  localparam logic [AW-1:0] A_VA_LO   = 7'h66;
  localparam logic [AW-1:0] A_EXT_EN  = 7'h67;
  localparam logic [AW-1:0] A_CTRL    = 7'h68;
  localparam logic [AW-1:0] A_STATUS  = 7'h69;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} seq_st_e;
endpackage

// File: rtl/smon_seq.sv
module smon_seq
  import smon_pkg::*;
#(
  parameter int NCH     = 7,
  parameter int NUM_EXT = 4,
  parameter int CW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_en,
  input  logic               adc_done,
  output logic               adc_start,
  output logic [CW-1:0]      chan,
  output logic               smp_valid
);
  seq_st_e         st_q, st_d;
  logic [CW-1:0]   chan_q, chan_d, nxt;
  logic [NCH-1:0]  en_vec;

  assign en_vec = {ext_en, {NUM_INT{1'b1}}};

  // next enabled channel after the current one, wrapping
  always_comb begin : next_search
    logic [CW:0] cand;
    logic        found;
    nxt   = chan_q;
    found = 1'b0;
    cand  = '0;
    for (int i = 1; i <= NCH; i++) begin
      cand = {1'b0, chan_q} + (CW+1)'(i);
      if (cand >= (CW+1)'(NCH)) cand = cand - (CW+1)'(NCH);
      if (!found && en_vec[cand[CW-1:0]]) begin
        nxt   = cand[CW-1:0];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    chan_d = chan_q;
    case (st_q)
      ST_IDLE:  st_d = ST_START;
      ST_START: st_d = ST_WAIT;
      ST_WAIT: if (adc_done) begin
        st_d   = ST_START;
        chan_d = nxt;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      chan_q <= '0;
    end else begin
      st_q   <= st_d;
      chan_q <= chan_d;
    end
  end

  assign adc_start = (st_q == ST_START);
  assign chan      = chan_q;
  assign smp_valid = (st_q == ST_WAIT) && adc_done;
endmodule

// File: rtl/smon_store.sv
module smon_store #(
  parameter int NCH = 7,
  parameter int DW  = 10,
  parameter int CW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [CW-1:0] smp_chan,
  input  logic [DW-1:0] smp_data,
  output logic [DW-1:0] last_o [NCH],
  output logic [DW-1:0] max_o  [NCH],
  output logic [DW-1:0] min_o  [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          hit;
    logic [DW-1:0] last_q, max_q, min_q;
    logic [DW-1:0] last_d, max_d, min_d;

    assign hit = smp_valid && (smp_chan == CW'(g));

    always_comb begin
      last_d = last_q;
      max_d  = max_q;
      min_d  = min_q;
      if (hit) begin
        last_d = smp_data;
        if (smp_data > max_q) max_d = smp_data;
        if (smp_data < min_q) min_d = smp_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q <= '0;
        max_q  <= '0;
        min_q  <= '1;
      end else begin
        last_q <= last_d;
        max_q  <= max_d;
        min_q  <= min_d;
      end
    end

    assign last_o[g] = last_q;
    assign max_o[g]  = max_q;
    assign min_o[g]  = min_q;
  end
endmodule

// File: rtl/smon_alarm.sv
module smon_alarm #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_temp,
  input  logic          smp_vcore,
  input  logic          smp_vaux,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-1:0] thr_temp_hi,
  input  logic [DW-1:0] pd_lim,
  input  logic [DW-1:0] pd_rel,
  input  logic [DW-1:0] vc_hi,
  input  logic [DW-1:0] vc_lo,
  input  logic [DW-1:0] va_hi,
  input  logic [DW-1:0] va_lo,
  input  logic          clr_req,
  input  logic [DW-1:0] temp_last,
  output logic          alarm_temp,
  output logic          alarm_vcore,
  output logic          alarm_vaux,
  output logic          pd_req
);
  logic at_q, at_d, avc_q, avc_d, ava_q, ava_d, pd_q, pd_d;

  always_comb begin
    at_d  = at_q;
    avc_d = avc_q;
    ava_d = ava_q;
    pd_d  = pd_q;
    if (smp_temp)  at_d  = (smp_data > thr_temp_hi);
    if (smp_vcore) avc_d = (smp_data > vc_hi) || (smp_data < vc_lo);
    if (smp_vaux)  ava_d = (smp_data > va_hi) || (smp_data < va_lo);
    if (clr_req && (temp_last < pd_rel)) pd_d = 1'b0;
    if (smp_temp && (smp_data > pd_lim)) pd_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_q  <= 1'b0;
      avc_q <= 1'b0;
      ava_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      at_q  <= at_d;
      avc_q <= avc_d;
      ava_q <= ava_d;
      pd_q  <= pd_d;
    end
  end

  assign alarm_temp  = at_q;
  assign alarm_vcore = avc_q;
  assign alarm_vaux  = ava_q;
  assign pd_req      = pd_q;
endmodule

// File: rtl/smon_top.sv
module smon_top
  import smon_pkg::*;
#(
  parameter  int NUM_EXT = 4,
  parameter  int DW      = 10,
  parameter  int BW      = 32,
  localparam int NCH     = NUM_INT + NUM_EXT,
  localparam int CW      = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          adc_start,
  output logic [CW-1:0] adc_chan,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          alarm_temp,
  output logic          alarm_vcore,
  output logic          alarm_vaux,
  output logic          pd_req
);
  logic [1:0]         rs_q;
  logic               rst_ni;
  logic               smp_valid;
  logic [DW-1:0]      last_v [NCH];
  logic [DW-1:0]      max_v  [NCH];
  logic [DW-1:0]      min_v  [NCH];
  logic [DW-1:0]      thr_temp_hi, pd_lim, pd_rel, vc_hi, vc_lo, va_hi, va_lo;
  logic [NUM_EXT-1:0] ext_en_q;
  logic               clr_req;
  logic [BW-1:0]      rd_d, rdata_q;
  logic               unused_wdata;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  smon_seq #(.NCH(NCH), .NUM_EXT(NUM_EXT), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_ni), .ext_en(ext_en_q), .adc_done(adc_done),
    .adc_start(adc_start), .chan(adc_chan), .smp_valid(smp_valid)
  );

  smon_store #(.NCH(NCH), .DW(DW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_ni), .smp_valid(smp_valid), .smp_chan(adc_chan),
    .smp_data(adc_data), .last_o(last_v), .max_o(max_v), .min_o(min_v)
  );

  assign clr_req = wr_en && (addr == A_CTRL) && wdata[0];

  smon_alarm #(.DW(DW)) u_alarm (
    .clk(clk), .rst_n(rst_ni),
    .smp_temp (smp_valid && (adc_chan == CW'(CH_TEMP))),
    .smp_vcore(smp_valid && (adc_chan == CW'(CH_VCORE))),
    .smp_vaux (smp_valid && (adc_chan == CW'(CH_VAUX))),
    .smp_data(adc_data), .thr_temp_hi(thr_temp_hi), .pd_lim(pd_lim),
    .pd_rel(pd_rel), .vc_hi(vc_hi), .vc_lo(vc_lo), .va_hi(va_hi),
    .va_lo(va_lo), .clr_req(clr_req), .temp_last(last_v[CH_TEMP]),
    .alarm_temp(alarm_temp), .alarm_vcore(alarm_vcore),
    .alarm_vaux(alarm_vaux), .pd_req(pd_req)
  );

  // configuration registers, each with its own write enable
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_temp_hi <= '1;
      pd_lim      <= '1;
      pd_rel      <= '0;
      vc_hi       <= '1;
      vc_lo       <= '0;
      va_hi       <= '1;
      va_lo       <= '0;
      ext_en_q    <= '1;
    end else begin
      if (wr_en && addr == A_TEMP_HI) thr_temp_hi <= wdata[DW-1:0];
      if (wr_en && addr == A_PD_LIM)  pd_lim      <= wdata[DW-1:0];
      if (wr_en && addr == A_PD_REL)  pd_rel      <= wdata[DW-1:0];
      if (wr_en && addr == A_VC_HI)   vc_hi       <= wdata[DW-1:0];
      if (wr_en && addr == A_VC_LO)   vc_lo       <= wdata[DW-1:0];
      if (wr_en && addr == A_VA_HI)   va_hi       <= wdata[DW-1:0];
      if (wr_en && addr == A_VA_LO)   va_lo       <= wdata[DW-1:0];
      if (wr_en && addr == A_EXT_EN)  ext_en_q    <= wdata[NUM_EXT-1:0];
    end
  end
  assign unused_wdata = ^wdata;

  // read multiplexer
  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr == A_LAST + AW'(c)) rd_d = BW'(last_v[c]);
      if (addr == A_MAX  + AW'(c)) rd_d = BW'(max_v[c]);
      if (addr == A_MIN  + AW'(c)) rd_d = BW'(min_v[c]);
    end
    case (addr)
      A_TEMP_HI: rd_d = BW'(thr_temp_hi);
      A_PD_LIM:  rd_d = BW'(pd_lim);
      A_PD_REL:  rd_d = BW'(pd_rel);
      A_VC_HI:   rd_d = BW'(vc_hi);
      A_VC_LO:   rd_d = BW'(vc_lo);
      A_VA_HI:   rd_d = BW'(va_hi);
      A_VA_LO:   rd_d = BW'(va_lo);
      A_EXT_EN:  rd_d = BW'(ext_en_q);
      A_STATUS:  rd_d = BW'({pd_req, alarm_vaux, alarm_vcore, alarm_temp});
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end
  assign rdata = rdata_q;
endmodule

// File: rtl/smon_checker.sv
module smon_checker
  import smon_pkg::*;
#(
  parameter int NCH = 7,
  parameter int CW  = 3,
  parameter int DW  = 10,
  parameter int BW  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_start,
  input logic [CW-1:0] adc_chan,
  input logic          adc_done,
  input logic [DW-1:0] adc_data,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [BW-1:0] wdata,
  input logic [BW-1:0] rdata,
  input logic          alarm_temp,
  input logic          pd_req,
  input logic [DW-1:0] thr_temp_hi,
  input logic [DW-1:0] pd_lim
);
  p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ({1'b0, adc_chan} < (CW+1)'(NCH)));

  p_temp_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && !adc_start && adc_chan == CW'(CH_TEMP) && adc_data > thr_temp_hi)
    |=> alarm_temp);

  p_pd_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && !adc_start && adc_chan == CW'(CH_TEMP) && adc_data > pd_lim)
    |=> pd_req);

  p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !(wr_en && addr == A_CTRL && wdata[0])) |=> pd_req);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind smon_top smon_checker #(.NCH(NCH), .CW(CW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_ni), .adc_start(adc_start), .adc_chan(adc_chan),
  .adc_done(adc_done), .adc_data(adc_data), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_temp(alarm_temp),
  .pd_req(pd_req), .thr_temp_hi(thr_temp_hi), .pd_lim(pd_lim)
);

// File: tb/smon_top_bench.sv
module smon_top_bench;
  import smon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_EXT    = 4;
  localparam int DW         = 10;
  localparam int BW         = 32;
  localparam int NCH        = 3 + NUM_EXT;
  localparam int CW         = $clog2(NCH);
  localparam int LAT        = 3;
  localparam int NVEC       = 8;
  localparam int VEC_CH  [NVEC] = '{3, 3, 3, 4, 4, 5, 6, 6};
  localparam int VEC_VAL [NVEC] = '{'h050, 'h3F0, 'h120, 'h000, 'h3FF, 'h155, 'h2AA, 'h001};

  logic          clk, rst_n;
  logic          adc_start, adc_done;
  logic [CW-1:0] adc_chan;
  logic [DW-1:0] adc_data;
  logic          rd_en, wr_en;
  logic [AW-1:0] addr;
  logic [BW-1:0] wdata, rdata;
  logic          alarm_temp, alarm_vcore, alarm_vaux, pd_req;

  smon_top #(.NUM_EXT(NUM_EXT), .DW(DW), .BW(BW)) u_smon_top (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_data(adc_data), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_temp(alarm_temp),
    .alarm_vcore(alarm_vcore), .alarm_vaux(alarm_vaux), .pd_req(pd_req)
  );

  int            checks, errors;
  bit            finished;
  logic [DW-1:0] sens [NCH];
  int            conv_cnt [NCH];
  int            log_ch [512];
  int            log_n;
  int            overlap_err;
  int            exp_max [NCH];
  int            exp_min [NCH];

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // converter model: answers each start after LAT cycles
  initial begin
    adc_done = 1'b0;
    adc_data = '0;
    forever begin
      if (adc_start !== 1'b1) @(negedge clk);
      else begin
        int ch;
        ch = int'(adc_chan);
        for (int k = 0; k < LAT; k++) begin
          @(negedge clk);
          if (adc_start === 1'b1) overlap_err++;
        end
        adc_done = 1'b1;
        adc_data = sens[ch];
        conv_cnt[ch]++;
        if (log_n < 512) begin
          log_ch[log_n] = ch;
          log_n++;
        end
        @(negedge clk);
        adc_done = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, output logic [BW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_conv(input int ch, input int n);
    int target;
    target = conv_cnt[ch] + n;
    while (conv_cnt[ch] < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_sens(input int ch, input int v);
    sens[ch] = DW'(v);
    wait_conv(ch, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] rv, hold;
    bit ok;
    int cnt4, cnt6, lstart;
    checks = 0; errors = 0; finished = 0; log_n = 0; overlap_err = 0;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    for (int c = 0; c < NCH; c++) begin
      sens[c] = DW'(100 + 10*c);
      conv_cnt[c] = 0;
    end
    repeat (4) @(negedge clk);
    // R1: outputs in reset
    chk("R1 start in reset", 32'(adc_start), 0);
    chk("R1 alarms in reset", {28'd0, pd_req, alarm_vaux, alarm_vcore, alarm_temp}, 0);
    rst_n = 1'b1;
    // R1: channel 6 not yet converted
    reg_rd(A_MAX + 7'd6, rv);  chk("R1 max reset", rv, 32'h000);
    reg_rd(A_MIN + 7'd6, rv);  chk("R1 min reset", rv, 32'h3FF);
    reg_rd(A_LAST + 7'd6, rv); chk("R1 last reset", rv, 32'h000);

    // R2: order from reset
    while (log_n < NCH + 1) @(negedge clk);
    @(negedge clk);
    ok = 1;
    for (int i = 0; i <= NCH; i++) if (log_ch[i] != i % NCH) ok = 0;
    chk("R2 order", 32'(ok), 1);
    for (int c = 0; c < NCH; c++) begin
      exp_max[c] = int'(sens[c]);
      exp_min[c] = int'(sens[c]);
    end

    // R3/R4: vector table
    for (int v = 0; v < NVEC; v++) begin
      int ch;
      ch = VEC_CH[v];
      set_sens(ch, VEC_VAL[v]);
      if (VEC_VAL[v] > exp_max[ch]) exp_max[ch] = VEC_VAL[v];
      if (VEC_VAL[v] < exp_min[ch]) exp_min[ch] = VEC_VAL[v];
      reg_rd(A_LAST + AW'(ch), rv); chk("R3 latest", rv, 32'(VEC_VAL[v]));
      reg_rd(A_MAX + AW'(ch), rv);  chk("R4 max", rv, 32'(exp_max[ch]));
      reg_rd(A_MIN + AW'(ch), rv);  chk("R4 min", rv, 32'(exp_min[ch]));
    end

    // R9: result registers ignore writes
    reg_wr(A_LAST + 7'd3, 32'h0AB);
    reg_wr(A_MAX + 7'd3, 32'h0AB);
    reg_wr(A_MIN + 7'd3, 32'h0AB);
    reg_rd(A_LAST + 7'd3, rv); chk("R9 latest", rv, 32'h120);
    reg_rd(A_MAX + 7'd3, rv);  chk("R9 max", rv, 32'(exp_max[3]));
    reg_rd(A_MIN + 7'd3, rv);  chk("R9 min", rv, 32'(exp_min[3]));

    // R10: readback, unmapped, hold
    reg_wr(A_TEMP_HI, 32'h300);
    reg_rd(A_TEMP_HI, rv); chk("R10 threshold readback", rv, 32'h300);
    reg_rd(7'h7F, rv);     chk("R10 unmapped", rv, 32'h0);
    reg_rd(A_TEMP_HI, hold);
    repeat (5) @(negedge clk);
    chk("R10 hold", rdata, hold);

    // R5: temperature alarm
    set_sens(0, 'h310); chk("R5 above", 32'(alarm_temp), 1);
    set_sens(0, 'h300); chk("R5 equal clears", 32'(alarm_temp), 0);

    // R6: supply alarms
    set_sens(1, 'h200);
    reg_wr(A_VC_HI, 32'h250);
    reg_wr(A_VC_LO, 32'h150);
    wait_conv(1, 2);    chk("R6 vcore in range", 32'(alarm_vcore), 0);
    set_sens(1, 'h100); chk("R6 vcore low", 32'(alarm_vcore), 1);
    set_sens(1, 'h260); chk("R6 vcore high", 32'(alarm_vcore), 1);
    set_sens(1, 'h250); chk("R6 vcore at bound", 32'(alarm_vcore), 0);
    reg_wr(A_VA_HI, 32'h050);
    wait_conv(2, 2);    chk("R6 vaux high", 32'(alarm_vaux), 1);
    reg_rd(A_STATUS, rv); chk("R10 status", rv, 32'h4);
    reg_wr(A_VA_HI, 32'h3FF);
    wait_conv(2, 2);    chk("R6 vaux clears", 32'(alarm_vaux), 0);

    // R7/R8: power-down request
    reg_wr(A_PD_LIM, 32'h380);
    reg_wr(A_PD_REL, 32'h200);
    set_sens(0, 'h380); chk("R7 at limit", 32'(pd_req), 0);
    set_sens(0, 'h390); chk("R7 above limit", 32'(pd_req), 1);
    set_sens(0, 'h300); chk("R7 latched", 32'(pd_req), 1);
    reg_wr(A_CTRL, 32'h1); chk("R8 clear refused while hot", 32'(pd_req), 1);
    set_sens(0, 'h1FF); chk("R7 latched when cool", 32'(pd_req), 1);
    reg_wr(A_CTRL, 32'h0); chk("R8 zero write", 32'(pd_req), 1);
    reg_wr(A_CTRL, 32'h1); chk("R8 clear accepted", 32'(pd_req), 0);

    // R11: external mask
    reg_wr(A_EXT_EN, 32'h5);
    wait_conv(0, 1);
    cnt4 = conv_cnt[4]; cnt6 = conv_cnt[6]; lstart = log_n;
    sens[4] = 10'h111;
    wait_conv(3, 3);
    chk("R11 ch4 skipped", 32'(conv_cnt[4]), 32'(cnt4));
    chk("R11 ch6 skipped", 32'(conv_cnt[6]), 32'(cnt6));
    ok = 1;
    for (int i = lstart; i < log_n - 1; i++) begin
      int e;
      case (log_ch[i])
        0: e = 1; 1: e = 2; 2: e = 3; 3: e = 5; 5: e = 0;
        default: e = -1;
      endcase
      if (log_ch[i+1] != e) ok = 0;
    end
    chk("R2 R11 masked order", 32'(ok), 1);
    reg_rd(A_LAST + 7'd4, rv); chk("R11 disabled unchanged", rv, 32'h3FF);

    // R12: no overlapping starts
    chk("R12 start overlap", 32'(overlap_err), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule